// File: doc/BRIEF.md
# Two-Way Set-Associative Page Translation Buffer

This block caches recent page translations for a 4 KB page size. It holds 128 entries as two ways of 64 sets. A requester presents an effective page number, and in the same cycle the block says whether the page is present. On a hit it also returns the physical page number together with that page's referenced and changed flags. No register lies between the lookup and the answer.

On a miss the block raises a search request to an outside table-search agent without any software action. It latches the missing page number and holds the request until the agent hands back a physical page number. The block then writes that translation into the set. It fills an empty way first and otherwise replaces the least recently used way. Only one search is outstanding at a time. Lookups made while a search is outstanding still hit on resident pages, but their misses raise no new request.

The block sets the referenced flag of a page on every hit and sets the changed flag on every store hit. When a store hits a page whose changed flag is still clear, it pulses an update output so that the page table in memory can be brought up to date. Two invalidation commands are provided: one empties the whole buffer, and the other empties both ways of one set.

Top module: `ptlb_top`

## Requirements
- R1: When `lk_valid` is high and the page is resident, `lk_hit` is 1 and `lk_ppn` carries the stored physical page number in the same cycle, with no clock edge in between.
- R2: A valid lookup of a page that is not resident gives `lk_miss`=1 and `lk_hit`=0. Bits [5:0] of the effective page number select the set, and bits [19:6] form the tag.
- R3: A miss while no search is outstanding raises `srch_req` from the next cycle, with `srch_epn` equal to the missed page. `srch_req` stays high until a cycle with `rf_valid` high, and is low in the cycle after that one.
- R4: While a search is outstanding, a lookup miss changes neither `srch_req` nor `srch_epn`, and resident pages still hit.
- R5: An accepted refill installs `rf_ppn` for the latched page. If one way of the set is empty, the fill goes there (way 0 is checked first). The other page already in the set is kept. `rf_valid` while no search is outstanding has no effect.
- R6: When both ways are full, the fill replaces the way that was not most recently hit or filled.
- R7: A newly installed entry reports `lk_ref`=0 and `lk_chg`=0. Every hit sets the referenced flag, which is seen on later lookups. A lookup reports the flags as they were before that lookup.
- R8: A store hit sets the changed flag. `lk_upd` is 1 in exactly the cycle of a store hit whose changed flag was 0, and it is 0 for loads, for misses and for store hits on pages already changed.
- R9: `inv_all` clears every entry in one cycle. It also wins over a refill accepted in the same cycle.
- R10: `inv_one` clears both ways of the set given by `inv_epn[5:0]` and leaves every other set unchanged. It also wins over a refill into that set in the same cycle.
- R11: After reset no page is resident and `srch_req` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| lk_valid | input | 1 | Lookup present this cycle |
| lk_store | input | 1 | Lookup is a store access |
| lk_epn | input | 20 | Effective page number of the lookup |
| lk_hit | output | 1 | Page resident |
| lk_miss | output | 1 | Valid lookup, page not resident |
| lk_ppn | output | 20 | Physical page number on hit, else 0 |
| lk_ref | output | 1 | Referenced flag before this lookup |
| lk_chg | output | 1 | Changed flag before this lookup |
| lk_upd | output | 1 | Store hit on a page whose changed flag was clear |
| srch_req | output | 1 | Search request outstanding |
| srch_epn | output | 20 | Page number being searched |
| rf_valid | input | 1 | Refill answer present |
| rf_ppn | input | 20 | Physical page number of the refill |
| inv_all | input | 1 | Invalidate every entry |
| inv_one | input | 1 | Invalidate both ways of one set |
| inv_epn | input | 20 | Page number whose set is invalidated |

## Verification
The collision that matters is a refill being accepted in the same cycle as an invalidation, whether of the whole buffer or of the set that the refill targets. The bench creates a pending search and then drives `rf_valid` together with `inv_all` or `inv_one` on one clock edge. It checks that the request is retired and that a later lookup of the refilled page misses. It also checks hits and misses running alongside an outstanding search: resident pages must still hit, and the latched search page must stay fixed.

// File: rtl/ptlb_pkg.sv
package ptlb_pkg;

  // Way chosen for a fill: empty way 0, then empty way 1, then the LRU way.
  function automatic logic pick_victim(input logic v0, input logic v1, input logic lru_way);
    if (!v0)      return 1'b0;
    else if (!v1) return 1'b1;
    else          return lru_way;
  endfunction

  // Store hit on a clean page needs a page-table update.
  function automatic logic needs_update(input logic valid, input logic hit,
                                        input logic store, input logic chg);
    return valid && hit && store && !chg;
  endfunction

endpackage

// File: rtl/ptlb_way.sv
module ptlb_way #(
  parameter int TAG_W = 14,
  parameter int PPN_W = 20,
  parameter int SETS  = 64,
  parameter int IDX_W = 6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [IDX_W-1:0] rd_idx,
  input  logic [TAG_W-1:0] rd_tag,
  output logic             hit,
  output logic [PPN_W-1:0] rd_ppn,
  output logic             rd_ref,
  output logic             rd_chg,
  input  logic             acc_en,
  input  logic             acc_store,
  input  logic             wr_en,
  input  logic [IDX_W-1:0] wr_idx,
  input  logic [TAG_W-1:0] wr_tag,
  input  logic [PPN_W-1:0] wr_ppn,
  output logic             fill_vld,
  input  logic             inv_all,
  input  logic             inv_one,
  input  logic [IDX_W-1:0] inv_idx
);

  logic [SETS-1:0]  vld_q;
  logic [SETS-1:0]  ref_q;
  logic [SETS-1:0]  chg_q;
  logic [TAG_W-1:0] tag_q [SETS];
  logic [PPN_W-1:0] ppn_q [SETS];

  assign hit      = vld_q[rd_idx] && (tag_q[rd_idx] == rd_tag);
  assign rd_ppn   = ppn_q[rd_idx];
  assign rd_ref   = ref_q[rd_idx];
  assign rd_chg   = chg_q[rd_idx];
  assign fill_vld = vld_q[wr_idx];

  // Later statements take priority: access, then install, then invalidation.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vld_q <= '0;
      ref_q <= '0;
      chg_q <= '0;
    end else begin
      if (acc_en) begin
        ref_q[rd_idx] <= 1'b1;
        if (acc_store) chg_q[rd_idx] <= 1'b1;
      end
      if (wr_en) begin
        vld_q[wr_idx] <= 1'b1;
        ref_q[wr_idx] <= 1'b0;
        chg_q[wr_idx] <= 1'b0;
      end
      if (inv_one) vld_q[inv_idx] <= 1'b0;
      if (inv_all) vld_q <= '0;
    end
  end

  always_ff @(posedge clk) begin
    if (wr_en) begin
      tag_q[wr_idx] <= wr_tag;
      ppn_q[wr_idx] <= wr_ppn;
    end
  end

endmodule

// File: rtl/ptlb_lru.sv
module ptlb_lru #(
  parameter int SETS  = 64,
  parameter int IDX_W = 6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             hit_en,
  input  logic [IDX_W-1:0] hit_idx,
  input  logic             hit_way,
  input  logic             fill_en,
  input  logic [IDX_W-1:0] fill_idx,
  input  logic             fill_v0,
  input  logic             fill_v1,
  output logic             victim
);
  import ptlb_pkg::*;

  // lru_q[s] names the way to replace next in set s.
  logic [SETS-1:0] lru_q;

  assign victim = pick_victim(fill_v0, fill_v1, lru_q[fill_idx]);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lru_q <= '0;
    end else begin
      if (hit_en)  lru_q[hit_idx]  <= ~hit_way;
      if (fill_en) lru_q[fill_idx] <= ~victim;
    end
  end

endmodule

// File: rtl/ptlb_miss.sv
module ptlb_miss #(
  parameter int EPN_W = 20
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             miss_evt,
  input  logic [EPN_W-1:0] miss_epn,
  input  logic             rf_valid,
  output logic             srch_req,
  output logic [EPN_W-1:0] srch_epn,
  output logic             fill_go
);

  logic             pend_q;
  logic [EPN_W-1:0] epn_q;

  assign srch_req = pend_q;
  assign srch_epn = epn_q;
  assign fill_go  = pend_q && rf_valid;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_q <= 1'b0;
      epn_q  <= '0;
    end else if (pend_q) begin
      if (rf_valid) pend_q <= 1'b0;
    end else if (miss_evt) begin
      pend_q <= 1'b1;
      epn_q  <= miss_epn;
    end
  end

endmodule

// File: rtl/ptlb_top.sv
module ptlb_top #(
  parameter int EPN_W = 20,
  parameter int PPN_W = 20,
  parameter int SETS  = 64
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             lk_valid,
  input  logic             lk_store,
  input  logic [EPN_W-1:0] lk_epn,
  output logic             lk_hit,
  output logic             lk_miss,
  output logic [PPN_W-1:0] lk_ppn,
  output logic             lk_ref,
  output logic             lk_chg,
  output logic             lk_upd,
  output logic             srch_req,
  output logic [EPN_W-1:0] srch_epn,
  input  logic             rf_valid,
  input  logic [PPN_W-1:0] rf_ppn,
  input  logic             inv_all,
  input  logic             inv_one,
  input  logic [EPN_W-1:0] inv_epn
);
  import ptlb_pkg::*;

  localparam int WAYS  = 2;
  localparam int IDX_W = $clog2(SETS);
  localparam int TAG_W = EPN_W - IDX_W;

  logic [IDX_W-1:0] lk_idx, fill_idx, inv_idx;
  logic [TAG_W-1:0] lk_tag, fill_tag;
  logic [WAYS-1:0]  way_hit, way_ref, way_chg, way_fvld, way_wr;
  logic [PPN_W-1:0] way_ppn [WAYS];
  logic             hit_way, any_hit, victim, fill_go, miss_evt;

  assign lk_idx   = lk_epn[IDX_W-1:0];
  assign lk_tag   = lk_epn[EPN_W-1:IDX_W];
  assign fill_idx = srch_epn[IDX_W-1:0];
  assign fill_tag = srch_epn[EPN_W-1:IDX_W];
  assign inv_idx  = inv_epn[IDX_W-1:0];

  for (genvar w = 0; w < WAYS; w++) begin : g_way
    assign way_wr[w] = fill_go && (victim == 1'(w));
    ptlb_way #(.TAG_W(TAG_W), .PPN_W(PPN_W), .SETS(SETS), .IDX_W(IDX_W)) u_way (
      .clk      (clk),
      .rst_n    (rst_n),
      .rd_idx   (lk_idx),
      .rd_tag   (lk_tag),
      .hit      (way_hit[w]),
      .rd_ppn   (way_ppn[w]),
      .rd_ref   (way_ref[w]),
      .rd_chg   (way_chg[w]),
      .acc_en   (lk_valid && way_hit[w]),
      .acc_store(lk_store),
      .wr_en    (way_wr[w]),
      .wr_idx   (fill_idx),
      .wr_tag   (fill_tag),
      .wr_ppn   (rf_ppn),
      .fill_vld (way_fvld[w]),
      .inv_all  (inv_all),
      .inv_one  (inv_one),
      .inv_idx  (inv_idx)
    );
  end

  assign any_hit  = |way_hit;
  assign hit_way  = way_hit[1];
  assign lk_hit   = lk_valid && any_hit;
  assign miss_evt = lk_valid && !any_hit;
  assign lk_miss  = miss_evt;
  assign lk_ppn   = lk_hit ? way_ppn[hit_way] : '0;
  assign lk_ref   = lk_hit && way_ref[hit_way];
  assign lk_chg   = lk_hit && way_chg[hit_way];
  assign lk_upd   = needs_update(lk_valid, any_hit, lk_store, way_chg[hit_way]);

  ptlb_lru #(.SETS(SETS), .IDX_W(IDX_W)) u_lru (
    .clk     (clk),
    .rst_n   (rst_n),
    .hit_en  (lk_hit),
    .hit_idx (lk_idx),
    .hit_way (hit_way),
    .fill_en (fill_go),
    .fill_idx(fill_idx),
    .fill_v0 (way_fvld[0]),
    .fill_v1 (way_fvld[1]),
    .victim  (victim)
  );

  ptlb_miss #(.EPN_W(EPN_W)) u_miss (
    .clk     (clk),
    .rst_n   (rst_n),
    .miss_evt(miss_evt),
    .miss_epn(lk_epn),
    .rf_valid(rf_valid),
    .srch_req(srch_req),
    .srch_epn(srch_epn),
    .fill_go (fill_go)
  );

endmodule

// File: rtl/ptlb_chk.sv
module ptlb_chk #(
  parameter int EPN_W = 20,
  parameter int IDX_W = 6
) (
  input logic             clk,
  input logic             rst_n,
  input logic             lk_valid,
  input logic             lk_store,
  input logic [EPN_W-1:0] lk_epn,
  input logic             lk_hit,
  input logic             lk_miss,
  input logic             lk_chg,
  input logic             lk_upd,
  input logic             srch_req,
  input logic [EPN_W-1:0] srch_epn,
  input logic             rf_valid,
  input logic             fill_go,
  input logic             inv_all,
  input logic             inv_one,
  input logic [EPN_W-1:0] inv_epn
);

  a_r2_miss_excludes_hit: assert property (@(posedge clk) disable iff (!rst_n)
    lk_miss |-> (lk_valid && !lk_hit));

  a_r3_req_on_miss: assert property (@(posedge clk) disable iff (!rst_n)
    (lk_miss && !srch_req) |=> (srch_req && srch_epn == $past(lk_epn)));

  a_r3_req_drops: assert property (@(posedge clk) disable iff (!rst_n)
    (srch_req && rf_valid) |=> !srch_req);

  a_r4_req_held: assert property (@(posedge clk) disable iff (!rst_n)
    (srch_req && !rf_valid) |=> (srch_req && $stable(srch_epn)));

  a_r5_fill_needs_req: assert property (@(posedge clk) disable iff (!rst_n)
    fill_go |-> srch_req);

  a_r8_upd_store_hit: assert property (@(posedge clk) disable iff (!rst_n)
    lk_upd |-> (lk_valid && lk_store && lk_hit && !lk_chg));

  a_r9_all_cleared: assert property (@(posedge clk) disable iff (!rst_n)
    inv_all |=> !lk_hit);

  a_r10_set_cleared: assert property (@(posedge clk) disable iff (!rst_n)
    inv_one |=> !(lk_hit && lk_epn[IDX_W-1:0] == $past(inv_epn[IDX_W-1:0])));

endmodule

bind ptlb_top ptlb_chk #(.EPN_W(EPN_W), .IDX_W(IDX_W)) u_chk (
  .clk     (clk),
  .rst_n   (rst_n),
  .lk_valid(lk_valid),
  .lk_store(lk_store),
  .lk_epn  (lk_epn),
  .lk_hit  (lk_hit),
  .lk_miss (lk_miss),
  .lk_chg  (lk_chg),
  .lk_upd  (lk_upd),
  .srch_req(srch_req),
  .srch_epn(srch_epn),
  .rf_valid(rf_valid),
  .fill_go (fill_go),
  .inv_all (inv_all),
  .inv_one (inv_one),
  .inv_epn (inv_epn)
);

// File: tb/test_ptlb_top.sv
module test_ptlb_top;
  localparam int PERIOD = 10;
  localparam int EW = 20;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          lk_valid = 1'b0, lk_store = 1'b0;
  logic [EW-1:0] lk_epn = '0;
  logic          lk_hit, lk_miss, lk_ref, lk_chg, lk_upd, srch_req;
  logic [EW-1:0] lk_ppn, srch_epn;
  logic          rf_valid = 1'b0, inv_all = 1'b0, inv_one = 1'b0;
  logic [EW-1:0] rf_ppn = '0, inv_epn = '0;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 1'b0;

  ptlb_top i_ptlb_top (
    .clk(clk), .rst_n(rst_n), .lk_valid(lk_valid), .lk_store(lk_store), .lk_epn(lk_epn),
    .lk_hit(lk_hit), .lk_miss(lk_miss), .lk_ppn(lk_ppn), .lk_ref(lk_ref), .lk_chg(lk_chg),
    .lk_upd(lk_upd), .srch_req(srch_req), .srch_epn(srch_epn), .rf_valid(rf_valid),
    .rf_ppn(rf_ppn), .inv_all(inv_all), .inv_one(inv_one), .inv_epn(inv_epn)
  );

  always #(PERIOD/2) clk = ~clk;

  function automatic logic [EW-1:0] ppn_of(input logic [EW-1:0] e);
    return {e[7:0], e[19:8]} ^ 20'h3C96B;
  endfunction

  function automatic logic [EW-1:0] mk(input int tag, input int set);
    return EW'((tag << 6) | set);
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic drive(input logic lv, input logic st, input logic [EW-1:0] e,
                       input logic rv, input logic [EW-1:0] rp,
                       input logic ia, input logic io, input logic [EW-1:0] ie);
    @(negedge clk);
    lk_valid = lv; lk_store = st; lk_epn = e;
    rf_valid = rv; rf_ppn = rp;
    inv_all = ia; inv_one = io; inv_epn = ie;
    #1;
  endtask

  task automatic idle();
    drive(0, 0, '0, 0, '0, 0, 0, '0);
  endtask

  task automatic look(input logic [EW-1:0] e, input logic st);
    drive(1, st, e, 0, '0, 0, 0, '0);
  endtask

  // Expect a hit with the computed translation.
  task automatic exp_hit(input string req, input logic [EW-1:0] e);
    look(e, 0);
    chk(req, {lk_hit, lk_miss}, 2'b10);
    chk(req, lk_ppn, ppn_of(e));
  endtask

  task automatic exp_miss(input string req, input logic [EW-1:0] e);
    look(e, 0);
    chk(req, {lk_hit, lk_miss, lk_upd}, 3'b010);
  endtask

  // Called one cycle or more after the miss: request must be up, then refill.
  task automatic serve(input logic [EW-1:0] e);
    chk("R3 request raised", {srch_req, srch_epn}, {1'b1, e});
    drive(0, 0, '0, 1, ppn_of(e), 0, 0, '0);
    idle();
    chk("R3 request dropped", srch_req, 1'b0);
  endtask

  task automatic fill(input logic [EW-1:0] e);
    exp_miss("R2 absent page", e);
    idle();
    serve(e);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk("R11 no request in reset", srch_req, 1'b0);
    rst_n = 1'b1;
    idle();
    chk("R11 no request after reset", srch_req, 1'b0);

    // Sweep every set: fill two ways, then check LRU replacement.
    for (int s = 0; s < 64; s++) begin
      fill(mk(1, s));
      fill(mk(2, s));
      exp_hit("R1 R5 first way kept", mk(1, s));
      exp_hit("R1 R5 second way", mk(2, s));
      exp_hit("R6 touch way one", mk(1, s));
      fill(mk(3, s));
      exp_hit("R6 MRU survives", mk(1, s));
      exp_hit("R6 new entry", mk(3, s));
      exp_miss("R6 LRU evicted", mk(2, s));
      idle();
      serve(mk(2, s));
    end

    // Referenced and changed flags on set 40 entry just refilled (tag 2).
    look(mk(2, 40), 0);
    chk("R7 fresh entry flags", {lk_hit, lk_ref, lk_chg, lk_upd}, 4'b1000);
    look(mk(2, 40), 1);
    chk("R8 first store hit", {lk_hit, lk_ref, lk_chg, lk_upd}, 4'b1101);
    look(mk(2, 40), 1);
    chk("R8 store on changed page", {lk_hit, lk_ref, lk_chg, lk_upd}, 4'b1110);
    look(mk(2, 40), 0);
    chk("R7 R8 load after stores", {lk_hit, lk_ref, lk_chg, lk_upd}, 4'b1110);
    look(mk(5, 41), 1);
    chk("R8 store miss no update", {lk_miss, lk_upd}, 2'b10);
    idle();
    serve(mk(5, 41));
    look(mk(5, 41), 1);
    chk("R7 R8 installed clean", {lk_hit, lk_ref, lk_chg, lk_upd}, 4'b1001);

    // One outstanding search.
    exp_miss("R2 page A", mk(7, 50));
    idle();
    chk("R3 request A", {srch_req, srch_epn}, {1'b1, mk(7, 50)});
    exp_miss("R4 miss while pending", mk(8, 51));
    exp_hit("R4 hit while pending", mk(3, 50));
    idle();
    chk("R4 request unchanged", {srch_req, srch_epn}, {1'b1, mk(7, 50)});
    serve(mk(7, 50));
    exp_hit("R5 page A installed", mk(7, 50));
    exp_miss("R4 second miss not queued", mk(8, 51));
    idle();
    serve(mk(8, 51));

    // Refill with nothing outstanding is ignored.
    drive(0, 0, '0, 1, 20'h12345, 0, 0, '0);
    idle();
    chk("R5 stray refill no request", srch_req, 1'b0);
    exp_hit("R5 stray refill no effect B", mk(8, 51));
    exp_hit("R5 stray refill no effect A", mk(7, 50));

    // Invalidate one set.
    drive(0, 0, '0, 0, '0, 0, 1, mk(0, 10));
    exp_miss("R10 way a cleared", mk(3, 10));
    exp_miss("R10 way b cleared", mk(2, 10));
    exp_hit("R10 neighbour above", mk(3, 11));
    exp_hit("R10 neighbour below", mk(2, 9));
    idle();
    serve(mk(3, 10));

    // Invalidate one set in the same cycle as a refill into it.
    exp_miss("R2 page C", mk(9, 30));
    idle();
    drive(0, 0, '0, 1, ppn_of(mk(9, 30)), 0, 1, mk(0, 30));
    idle();
    chk("R10 refill accepted", srch_req, 1'b0);
    exp_miss("R10 invalidate wins", mk(9, 30));
    idle();
    serve(mk(9, 30));
    exp_hit("R5 refill after clear", mk(9, 30));

    // Invalidate all in the same cycle as a refill.
    exp_miss("R2 page D", mk(10, 20));
    idle();
    drive(0, 0, '0, 1, ppn_of(mk(10, 20)), 1, 0, '0);
    idle();
    chk("R9 refill accepted", srch_req, 1'b0);
    exp_miss("R9 invalidate wins", mk(10, 20));
    for (int s = 0; s < 64; s++) exp_miss("R9 all cleared", mk(3, s));
    idle();
    serve(mk(10, 20));
    exp_hit("R9 refill after clear", mk(10, 20));

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_bad);
      $finish;
    end
  end

endmodule